// File: doc/BRIEF.md
# Skewed-Load Test Expansion Sequencer

This block applies a skewed-load delay test to one scan chain and the primary inputs, and it can turn a single stored test into many different tests. A stored test has three parts: a scan-in state as wide as the chain, a primary-input vector, and one scan-in bit that is used for the launch shift. An expansion entry chooses one of the stored tests. It also gives a number of extra shift cycles and a flag that inverts the fill bit. The block first shifts the stored state into the chain, most significant position first. It then shifts the fill bit in for the requested number of extra cycles, performs one more shift as the launch, and finally pulses a single functional capture clock.

The extra shifts move the first-pattern state along the chain before the launch. Each count from 0 to the chain length, combined with each flag value, gives a different two-pattern test. That makes up to twice the chain length plus two tests from one stored test. A count of zero with the flag clear reproduces the stored test exactly. A shadow register follows every shift of the chain. It lets the surrounding logic or a bench see the first-pattern and second-pattern states.

Top module: `skew_expand_seq`

## Requirements
- R1: After reset, ready is 1, scan_en, capture and done are 0, and chain_mirror and pi_out are all zeros.
- R2: The entry is packed as {index, count, flag}. The flag is bit 0, the count occupies the next clog2(CHAIN_LEN+1) bits, and the index occupies the top bits. Stored test r sits at bits [r*REC_W +: REC_W] of stored_tests, packed as {state, pi, fill} with fill at bit 0. An index of NUM_TESTS or above selects record 0.
- R3: Once start is accepted, the block spends CHAIN_LEN cycles with scan_en high, presenting the stored state on scan_in highest bit first. After these cycles, chain_mirror equals the stored state.
- R4: On every cycle with scan_en high, chain_mirror bit j takes the previous bit j-1, and bit 0 takes scan_in. When scan_en is low, chain_mirror holds its value.
- R5: After the load, the block spends as many cycles as the count with scan_en high and scan_in equal to the stored fill bit XOR the flag.
- R6: Exactly one launch shift with the same fill bit follows the padding. With count 0 and flag 0, the second-pattern state equals the stored state shifted once with the stored fill bit.
- R7: Directly after the launch comes exactly one cycle with capture high and scan_en low.
- R8: From the first load cycle through the capture cycle, pi_out equals the primary-input vector of the selected test and does not change.
- R9: done is high for exactly the one cycle after capture. ready returns to 1 in the following cycle.
- R10: start is ignored while ready is 0. An entry presented during a test changes neither the shifted bits nor the pattern.
- R11: A count greater than CHAIN_LEN is treated as CHAIN_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to apply the entry, taken only when ready |
| entry | input | IDX_W+CNT_W+1 | Expansion entry {index, count, flag} |
| stored_tests | input | NUM_TESTS*REC_W | Packed stored tests {state, pi, fill} |
| ready | output | 1 | Idle and able to accept start |
| scan_en | output | 1 | Scan shift enable |
| scan_in | output | 1 | Serial scan data into the chain |
| pi_out | output | PI_W | Primary-input vector held for the test |
| capture | output | 1 | Functional capture clock strobe |
| done | output | 1 | One-cycle pulse after capture |
| chain_mirror | output | CHAIN_LEN | Shadow copy of the scan chain contents |

## Verification
The embedded assertions check several rules on every cycle. Capture always comes directly after a shift cycle, and done always comes directly after capture. A launch is always followed by capture. The padding counter never goes past the clamped count, which never exceeds the chain length. The primary inputs stay stable while a test runs. Only the bench scenarios can confirm what is shifted: the serial order of the state bits, the fill polarity for each flag, the exact first-pattern and second-pattern states (including the worked example on a five-bit chain), the clamping of large counts, and that a start pulse in mid-test is ignored.

// File: rtl/skx_pkg.sv
package skx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PAD,
        ST_LAUNCH,
        ST_CAPTURE,
        ST_DONE
    } skx_state_e;
endpackage

// File: rtl/skx_test_select.sv
module skx_test_select #(
    parameter int CHAIN_LEN = 8,
    parameter int PI_W      = 4,
    parameter int NUM_TESTS = 4,
    parameter int IDX_W     = 2
) (
    input  logic [NUM_TESTS*(CHAIN_LEN+PI_W+1)-1:0] tests_flat,
    input  logic [IDX_W-1:0]                        idx,
    output logic [CHAIN_LEN-1:0]                    sel_state,
    output logic [PI_W-1:0]                         sel_pi,
    output logic                                    sel_fill
);
    localparam int REC_W = CHAIN_LEN + PI_W + 1;

    logic [REC_W-1:0] rec [NUM_TESTS];
    logic [REC_W-1:0] pick;

    for (genvar r = 0; r < NUM_TESTS; r++) begin : g_unpack
        assign rec[r] = tests_flat[r*REC_W +: REC_W];
    end

    always_comb begin
        pick = rec[0];
        for (int r = 1; r < NUM_TESTS; r++) begin
            if (32'(idx) == r) pick = rec[r];
        end
    end

    assign sel_fill  = pick[0];
    assign sel_pi    = pick[PI_W:1];
    assign sel_state = pick[REC_W-1:PI_W+1];
endmodule

// File: rtl/skx_chain_mirror.sv
module skx_chain_mirror #(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 shift_bit,
    output logic [CHAIN_LEN-1:0] chain
);
    logic [CHAIN_LEN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (shift_en) chain_d = {chain_q[CHAIN_LEN-2:0], shift_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign chain = chain_q;
endmodule

// File: rtl/skx_ctrl.sv
module skx_ctrl
    import skx_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int PI_W      = 4,
    parameter int CNT_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CHAIN_LEN-1:0] sel_state,
    input  logic [PI_W-1:0]      sel_pi,
    input  logic                 sel_fill,
    input  logic [CNT_W-1:0]     pad_req,
    input  logic                 invert,
    output logic                 ready,
    output logic                 scan_en,
    output logic                 scan_in,
    output logic                 capture,
    output logic                 done,
    output logic [PI_W-1:0]      pi_out
);
    localparam logic [CNT_W-1:0] LEN_C  = CNT_W'(CHAIN_LEN);
    localparam logic [CNT_W-1:0] LAST_L = CNT_W'(CHAIN_LEN - 1);

    typedef struct packed {
        skx_state_e           st;
        logic [CNT_W-1:0]     cnt;
        logic [CNT_W-1:0]     pad_n;
        logic [CHAIN_LEN-1:0] sh;
        logic                 fill;
        logic [PI_W-1:0]      pi;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_LOAD;
                    r_d.cnt   = '0;
                    r_d.sh    = sel_state;
                    r_d.pi    = sel_pi;
                    r_d.fill  = sel_fill ^ invert;
                    r_d.pad_n = (pad_req > LEN_C) ? LEN_C : pad_req;
                end
            end
            ST_LOAD: begin
                r_d.sh = {r_q.sh[CHAIN_LEN-2:0], 1'b0};
                if (r_q.cnt == LAST_L) begin
                    r_d.cnt = '0;
                    r_d.st  = (r_q.pad_n == '0) ? ST_LAUNCH : ST_PAD;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_PAD: begin
                if (r_q.cnt == r_q.pad_n - 1'b1) begin
                    r_d.cnt = '0;
                    r_d.st  = ST_LAUNCH;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_LAUNCH:  r_d.st = ST_CAPTURE;
            ST_CAPTURE: r_d.st = ST_DONE;
            ST_DONE:    r_d.st = ST_IDLE;
            default:    r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.pad_n <= '0;
            r_q.sh    <= '0;
            r_q.fill  <= 1'b0;
            r_q.pi    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        ready   = (r_q.st == ST_IDLE);
        scan_en = (r_q.st == ST_LOAD) || (r_q.st == ST_PAD) || (r_q.st == ST_LAUNCH);
        capture = (r_q.st == ST_CAPTURE);
        done    = (r_q.st == ST_DONE);
        if (r_q.st == ST_LOAD)                              scan_in = r_q.sh[CHAIN_LEN-1];
        else if (r_q.st == ST_PAD || r_q.st == ST_LAUNCH)   scan_in = r_q.fill;
        else                                                scan_in = 1'b0;
        pi_out  = r_q.pi;
    end

    // R6 and R7: a launch is always followed by the capture cycle
    a_r6_launch_then_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LAUNCH) |=> (r_q.st == ST_CAPTURE));

    // R5 and R11: padding never passes the clamped count, and the clamp never exceeds the chain
    a_r5_pad_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PAD) |-> (r_q.cnt < r_q.pad_n));

    a_r11_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |-> (r_q.pad_n <= LEN_C));

    // R3: the load counter stays within the chain length
    a_r3_load_count: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOAD) |-> (r_q.cnt <= LAST_L));
endmodule

// File: rtl/skew_expand_seq.sv
module skew_expand_seq #(
    parameter int CHAIN_LEN = 8,
    parameter int PI_W      = 4,
    parameter int NUM_TESTS = 4,
    localparam int IDX_W    = (NUM_TESTS > 1) ? $clog2(NUM_TESTS) : 1,
    localparam int CNT_W    = $clog2(CHAIN_LEN + 1),
    localparam int ENTRY_W  = IDX_W + CNT_W + 1,
    localparam int REC_W    = CHAIN_LEN + PI_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [ENTRY_W-1:0]         entry,
    input  logic [NUM_TESTS*REC_W-1:0] stored_tests,
    output logic                       ready,
    output logic                       scan_en,
    output logic                       scan_in,
    output logic [PI_W-1:0]            pi_out,
    output logic                       capture,
    output logic                       done,
    output logic [CHAIN_LEN-1:0]       chain_mirror
);
    logic                 e_flag;
    logic [CNT_W-1:0]     e_cnt;
    logic [IDX_W-1:0]     e_idx;
    logic [CHAIN_LEN-1:0] s_state;
    logic [PI_W-1:0]      s_pi;
    logic                 s_fill;

    assign e_flag = entry[0];
    assign e_cnt  = entry[CNT_W:1];
    assign e_idx  = entry[ENTRY_W-1:CNT_W+1];

    skx_test_select #(
        .CHAIN_LEN(CHAIN_LEN), .PI_W(PI_W), .NUM_TESTS(NUM_TESTS), .IDX_W(IDX_W)
    ) u_sel (
        .tests_flat(stored_tests),
        .idx       (e_idx),
        .sel_state (s_state),
        .sel_pi    (s_pi),
        .sel_fill  (s_fill)
    );

    skx_ctrl #(
        .CHAIN_LEN(CHAIN_LEN), .PI_W(PI_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .sel_state(s_state),
        .sel_pi   (s_pi),
        .sel_fill (s_fill),
        .pad_req  (e_cnt),
        .invert   (e_flag),
        .ready    (ready),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .capture  (capture),
        .done     (done),
        .pi_out   (pi_out)
    );

    skx_chain_mirror #(.CHAIN_LEN(CHAIN_LEN)) u_mirror (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (scan_en),
        .shift_bit(scan_in),
        .chain    (chain_mirror)
    );

    // R7: capture only directly after a shift cycle
    a_r7_capture_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> $past(scan_en));

    // R9: done only directly after capture
    a_r9_done_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(capture));

    // R8: primary inputs stay fixed while a test is running
    a_r8_pi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !$past(ready)) |-> $stable(pi_out));

    // R4: the mirror holds while no shift happens
    a_r4_mirror_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!scan_en) |-> $stable(chain_mirror));
endmodule

// File: tb/sim_skew_expand_seq.sv
module sim_skew_expand_seq;
    localparam int K   = 5;
    localparam int PW  = 3;
    localparam int NT  = 4;
    localparam int RW  = K + PW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [5:0] entry = '0;
    logic [NT*RW-1:0] tests;
    logic ready, scan_en, scan_in, capture, done;
    logic [PW-1:0] pi_out;
    logic [K-1:0] chain_mirror;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [K-1:0]  st_tab [NT];
    logic [PW-1:0] pi_tab [NT];
    logic          fl_tab [NT];

    always #4 clk = ~clk;

    skew_expand_seq #(.CHAIN_LEN(K), .PI_W(PW), .NUM_TESTS(NT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .entry(entry),
        .stored_tests(tests), .ready(ready), .scan_en(scan_en),
        .scan_in(scan_in), .pi_out(pi_out), .capture(capture),
        .done(done), .chain_mirror(chain_mirror)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R2: entry packing {index[5:4], count[3:1], flag[0]}
    function automatic logic [5:0] mk_entry(input int idx, input int n, input bit fl);
        return {2'(idx), 3'(n), fl};
    endfunction

    task automatic run_entry(input int idx, input int n, input bit fl,
                             input bit lit, input logic [K-1:0] lit1,
                             input logic [K-1:0] lit2, input bit poke);
        logic [K-1:0] m;
        logic fb;
        int eff_n;
        int total;
        bit q[$];
        eff_n = (n > K) ? K : n;
        fb = fl_tab[idx] ^ fl;
        for (int i = 0; i < K; i++) q.push_back(st_tab[idx][K-1-i]);
        for (int i = 0; i <= eff_n; i++) q.push_back(fb);
        total = q.size();
        chk(ready == 1'b1, "R9", "ready before start", ready, 1);
        start = 1'b1;
        entry = mk_entry(idx, n, fl);
        @(negedge clk);
        start = 1'b0;
        m = chain_mirror;
        for (int i = 0; i < total; i++) begin
            chk(scan_en == 1'b1, (i < K) ? "R3" : "R5", "scan_en", scan_en, 1);
            chk(scan_in == q[i], (i < K) ? "R3" : "R5", "scan_in", scan_in, q[i]);
            chk(capture == 1'b0 && ready == 1'b0, "R10", "busy flags", {capture, ready}, 0);
            chk(pi_out == pi_tab[idx], "R8", "pi_out", pi_out, pi_tab[idx]);
            if (poke && i == 2) begin
                start = 1'b1;
                entry = mk_entry((idx + 1) % NT, 0, ~fl);
            end else begin
                start = 1'b0;
            end
            m = {m[K-2:0], q[i]};
            @(negedge clk);
            chk(chain_mirror == m, "R4", "mirror shift", chain_mirror, m);
            if (i == K - 1)
                chk(chain_mirror == st_tab[idx], "R3", "state after load", chain_mirror, st_tab[idx]);
            if (lit && i == K - 1 + eff_n)
                chk(chain_mirror == lit1, "R5", "first pattern", chain_mirror, lit1);
        end
        if (lit) chk(chain_mirror == lit2, "R6", "second pattern", chain_mirror, lit2);
        chk(scan_en == 1'b0 && capture == 1'b1, "R7", "capture cycle", {scan_en, capture}, 1);
        chk(pi_out == pi_tab[idx], "R8", "pi at capture", pi_out, pi_tab[idx]);
        @(negedge clk);
        chk(done == 1'b1 && capture == 1'b0 && scan_en == 1'b0, "R9", "done pulse",
            {done, capture, scan_en}, 4);
        chk(chain_mirror == m, "R4", "mirror hold", chain_mirror, m);
        @(negedge clk);
        chk(done == 1'b0 && ready == 1'b1, "R9", "back to idle", {done, ready}, 1);
    endtask

    initial begin
        st_tab[0] = 5'b00010; pi_tab[0] = 3'b001; fl_tab[0] = 1'b0;
        st_tab[1] = 5'b10110; pi_tab[1] = 3'b101; fl_tab[1] = 1'b1;
        st_tab[2] = 5'b11111; pi_tab[2] = 3'b010; fl_tab[2] = 1'b0;
        st_tab[3] = 5'b01001; pi_tab[3] = 3'b111; fl_tab[3] = 1'b1;
        for (int r = 0; r < NT; r++)
            tests[r*RW +: RW] = {st_tab[r], pi_tab[r], fl_tab[r]};
        repeat (3) @(negedge clk);
        chk(ready == 1'b1 && scan_en == 1'b0 && capture == 1'b0 && done == 1'b0,
            "R1", "reset flags", {ready, scan_en, capture, done}, 8);
        chk(chain_mirror == '0 && pi_out == '0, "R1", "reset data", chain_mirror, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: worked example, flag 1 and no padding gives 10100 (bit0 first)
        run_entry(0, 0, 1'b1, 1'b1, 5'b00010, 5'b00101, 1'b0);
        // R5: one pad with flag 0: first 00100, second 00010 (bit0 first)
        run_entry(0, 1, 1'b0, 1'b1, 5'b00100, 5'b01000, 1'b0);
        // R6: count 0 flag 0 reproduces stored test
        run_entry(0, 0, 1'b0, 1'b1, 5'b00010, 5'b00100, 1'b0);
        run_entry(1, 3, 1'b0, 1'b0, '0, '0, 1'b0);
        // R10: start pulse mid-test is ignored
        run_entry(2, 2, 1'b1, 1'b0, '0, '0, 1'b1);
        // R11: count 7 clamps to 5
        run_entry(3, 7, 1'b0, 1'b1, 5'b11111, 5'b11111, 1'b0);
        run_entry(1, 5, 1'b1, 1'b1, 5'b00000, 5'b00000, 1'b0);
        // R2: index 3 with flag, mixed count
        run_entry(3, 2, 1'b1, 1'b0, '0, '0, 1'b0);
        @(negedge clk);
        chk(ready == 1'b1 && scan_en == 1'b0, "R10", "idle stays idle", {ready, scan_en}, 2);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule